// File: doc/BRIEF.md
# Serial Set Reduction Accumulator

This block adds up a stream of integer values that arrive one per clock, grouped into back-to-back sets. It produces exactly one total for each set, and the totals come out in the order the sets arrived. All additions go through one adder with a three-stage pipeline. Three independent partial sums of the running set therefore circulate through that adder at all times.

When a new set begins, a fixed eight-step operand schedule runs. It folds the three partial sums of the finished set into one, while the first values of the new set are admitted into the pipeline. A single holding register carries one operand across the cycles in which the adder is busy with the other set. A one-entry output register captures the finished total.

A set opens on a valid value that carries the start marker, or on any valid value that follows an idle cycle. Dropping `in_valid` closes the current set; this is how the last set of a stream is flushed out. Idle cycles contribute zero, and the empty interval they form is never reported as a set.

Top module: `set_reduce_acc`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sum_valid` is 0 and `sum_value` is 0.
- R2: A set starts on a cycle with `in_valid`=1 and `in_first`=1, or on a cycle with `in_valid`=1 that follows a cycle with `in_valid`=0. Every later cycle with `in_valid`=1 and `in_first`=0 belongs to the same set.
- R3: The reported total of a set is the sum of all its values, each zero-extended from DATA_W to SUM_W bits.
- R4: Each set produces exactly one total, and totals appear in the order their sets arrived.
- R5: Let edge n be the clock edge at which the set following a given set starts, or at which `in_valid` is first sampled low after that set. The given set's total appears with `sum_valid`=1 for exactly one cycle, directly after edge n+7.
- R6: Sets of 8 or more values are summed correctly when they arrive back to back with no idle cycle between them.
- R7: Values presented with `in_valid`=0 do not change any total. An idle interval is never reported as a set. An idle interval of 8 or more cycles may separate two sets.
- R8: `sum_value` changes only in a cycle where `sum_valid` is 1, and otherwise holds the last reported total.
- R9: Totals are taken modulo 2^SUM_W, so a set whose true sum exceeds SUM_W bits reports the low SUM_W bits.
- R10: The internal adder returns the sum of its two operands exactly three cycles after they are issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A value is present this cycle |
| in_first | input | 1 | This value opens a new set |
| in_value | input | DATA_W | Unsigned value to accumulate |
| sum_valid | output | 1 | One-cycle pulse: a set total is on `sum_value` |
| sum_value | output | SUM_W | Total of the most recently completed set |

## Verification
On every cycle, the embedded properties check four things. The adder delivers its operand sum after three cycles, and the result pulse never lasts two cycles. The reported total moves only together with that pulse. No set opens while the drain schedule from the previous boundary is still running. Whether the schedule pairs the correct operands can only be seen in the bench's scenarios. The bench compares each total against its own behavioural model on the exact expected cycle. Its scenarios cover minimum-size sets back to back, random sizes, idle gaps of exactly the minimum length, implicit starts after idle, ignored idle data and wrapping totals.

// File: rtl/sra_pkg.sv
package sra_pkg;

  localparam int ADD_LAT = 3;
  localparam int SEQ_LEN = 8;
  localparam int STEP_W  = $clog2(SEQ_LEN);

  typedef enum logic [1:0] {
    SRC_IN   = 2'd0,
    SRC_HOLD = 2'd1,
    SRC_PIPE = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;

  typedef struct packed {
    src_e opa;
    src_e opb;
    logic hold_ld;
    logic hold_from_in;
    logic emit;
  } op_t;

  localparam op_t OP_STEADY = '{opa: SRC_IN, opb: SRC_PIPE, hold_ld: 1'b0,
                                hold_from_in: 1'b0, emit: 1'b0};

  // Drain schedule after a set boundary; step 0 runs in the boundary cycle.
  function automatic op_t step_op(input logic [STEP_W-1:0] k);
    op_t o;
    o = OP_STEADY;
    case (k)
      3'd0: begin o.opb = SRC_ZERO; o.hold_ld = 1'b1; end
      3'd1: begin o.opa = SRC_HOLD; o.hold_ld = 1'b1; o.hold_from_in = 1'b1; end
      3'd2: begin o.opa = SRC_HOLD; o.opb = SRC_IN; o.hold_ld = 1'b1; end
      3'd4: begin o.opa = SRC_HOLD; o.hold_ld = 1'b1; o.hold_from_in = 1'b1; end
      3'd7: begin o.opb = SRC_HOLD; o.emit = 1'b1; end
      default: o = OP_STEADY;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/sra_pipe_add.sv
module sra_pipe_add #(
  parameter int W   = 36,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  logic [W-1:0] stage_q [LAT];

  generate
    for (genvar k = 0; k < LAT; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[k] <= '0;
          else     stage_q[k] <= a + b;
        end
      end else begin : g_delay
        always_ff @(posedge clk) begin
          if (rst) stage_q[k] <= '0;
          else     stage_q[k] <= stage_q[k-1];
        end
      end
    end
  endgenerate

  assign y = stage_q[LAT-1];

endmodule

// File: rtl/sra_ctrl.sv
module sra_ctrl
  import sra_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_first,
  output op_t  op,
  output logic emit,
  output logic busy
);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic              open_q;
  logic              drain_real_q;
  logic              boundary;

  // A boundary opens a real set or closes one by going idle.
  assign boundary = in_valid ? (in_first || !open_q) : open_q;

  always_comb begin
    if (boundary)    op = step_op('0);
    else if (busy_q) op = step_op(step_q);
    else             op = OP_STEADY;
  end

  assign emit = busy_q && op.emit && drain_real_q;
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      step_q       <= '0;
      open_q       <= 1'b0;
      drain_real_q <= 1'b0;
    end else if (boundary) begin
      busy_q       <= 1'b1;
      step_q       <= STEP_W'(1);
      drain_real_q <= open_q;
      open_q       <= in_valid;
    end else if (busy_q) begin
      step_q <= step_q + 1'b1;
      if (step_q == STEP_W'(SEQ_LEN - 1)) busy_q <= 1'b0;
    end
  end

  AST_MIN_SET_SIZE: assert property (@(posedge clk) disable iff (rst)
    boundary |-> !busy_q); // R6

endmodule

// File: rtl/set_reduce_acc.sv
module set_reduce_acc
  import sra_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SUM_W  = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [DATA_W-1:0] in_value,
  output logic              sum_valid,
  output logic [SUM_W-1:0]  sum_value
);

  op_t              op;
  logic             emit;
  logic             busy;
  logic [SUM_W-1:0] x;
  logic [SUM_W-1:0] hold_q;
  logic [SUM_W-1:0] pipe_out;
  logic [SUM_W-1:0] opa;
  logic [SUM_W-1:0] opb;
  logic             sum_valid_q;
  logic [SUM_W-1:0] sum_q;
  logic [1:0]       warm_q;

  function automatic logic [SUM_W-1:0] pick(input src_e s, input logic [SUM_W-1:0] i,
                                            input logic [SUM_W-1:0] h,
                                            input logic [SUM_W-1:0] p);
    case (s)
      SRC_IN:   return i;
      SRC_HOLD: return h;
      SRC_PIPE: return p;
      default:  return '0;
    endcase
  endfunction

  assign x   = in_valid ? SUM_W'(in_value) : '0;
  assign opa = pick(op.opa, x, hold_q, pipe_out);
  assign opb = pick(op.opb, x, hold_q, pipe_out);

  sra_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_first (in_first),
    .op       (op),
    .emit     (emit),
    .busy     (busy)
  );

  sra_pipe_add #(.W(SUM_W), .LAT(ADD_LAT)) u_add (
    .clk (clk),
    .rst (rst),
    .a   (opa),
    .b   (opb),
    .y   (pipe_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= '0;
      sum_valid_q <= 1'b0;
      sum_q       <= '0;
      warm_q      <= '0;
    end else begin
      if (op.hold_ld) hold_q <= op.hold_from_in ? x : pipe_out;
      sum_valid_q <= emit;
      if (emit) sum_q <= pipe_out;
      if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
    end
  end

  assign sum_valid = sum_valid_q;
  assign sum_value = sum_q;

  AST_ADD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd3) |-> pipe_out == $past(opa + opb, 3)); // R10

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    sum_valid_q |=> !sum_valid_q); // R5

  AST_HOLD_TOTAL: assert property (@(posedge clk) disable iff (rst)
    (sum_q != $past(sum_q)) |-> sum_valid_q); // R8

  AST_STEADY_PAIR: assert property (@(posedge clk) disable iff (rst)
    (!busy && op.opb != SRC_ZERO) |-> (opa == x && opb == pipe_out)); // R3

endmodule

// File: tb/set_reduce_acc_bench.sv
module set_reduce_acc_bench;

  localparam int DATA_W = 32;
  localparam int SUM_W  = 36;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_first = 1'b0;
  logic [DATA_W-1:0] in_value = '0;
  logic              sum_valid;
  logic [SUM_W-1:0]  sum_value;

  always #10 clk = ~clk;

  set_reduce_acc #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_set_reduce_acc (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_value  (in_value),
    .sum_valid (sum_valid),
    .sum_value (sum_value)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  // behavioural model state
  bit               m_open = 1'b0;
  logic [SUM_W-1:0] m_acc = '0;
  logic [SUM_W-1:0] m_last = '0;
  logic [SUM_W-1:0] exp_sum_q[$];
  int               exp_due_q[$];

  task automatic fail(input string req, input string what, input longint act, input longint exp);
    n_fail++;
    $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
  endtask

  task automatic check_outputs();
    bit due;
    due = (exp_due_q.size() != 0) && (exp_due_q[0] == cyc);
    n_chk++;
    if (sum_valid !== due) fail("R5", "sum_valid timing", longint'(sum_valid), longint'(due));
    if (due) begin
      n_chk++;
      if (sum_value !== exp_sum_q[0])
        fail("R3", "set total (R4 order, R9 wrap)", longint'(sum_value), longint'(exp_sum_q[0]));
      m_last = exp_sum_q[0];
      void'(exp_sum_q.pop_front());
      void'(exp_due_q.pop_front());
    end else begin
      n_chk++;
      if (sum_value !== m_last) fail("R8", "held total", longint'(sum_value), longint'(m_last));
    end
  endtask

  task automatic model_step(input bit v, input bit f, input logic [DATA_W-1:0] val);
    bit start;
    start = v ? (f || !m_open) : m_open;
    if (start) begin
      if (m_open) begin
        exp_sum_q.push_back(m_acc);
        exp_due_q.push_back(cyc + 7);
      end
      m_open = v;
      m_acc  = v ? SUM_W'(val) : '0;
    end else if (v) begin
      m_acc = m_acc + SUM_W'(val);
    end
  endtask

  task automatic cycle(input bit v, input bit f, input logic [DATA_W-1:0] val);
    @(negedge clk);
    check_outputs();
    in_valid = v;
    in_first = f;
    in_value = val;
    @(posedge clk);
    cyc++;
    model_step(v, f, val);
  endtask

  // R2 R6: one set of n values; big selects values near the top of the range
  task automatic send_set(input int n, input bit mark, input bit big);
    for (int i = 0; i < n; i++) begin
      logic [DATA_W-1:0] val;
      val = big ? (32'hFFFF_FFFF - ($urandom % 256)) : ($urandom % 100000);
      cycle(1'b1, mark && (i == 0), val);
    end
  endtask

  // R7: idle cycles carry junk data that must be ignored
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, ($urandom % 2) == 1, $urandom);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (sum_valid !== 1'b0) fail("R1", "sum_valid in reset", longint'(sum_valid), 0);
    n_chk++;
    if (sum_value !== '0) fail("R1", "sum_value in reset", longint'(sum_value), 0);
    rst = 1'b0;

    // R6: minimum-size sets back to back
    for (int s = 0; s < 5; s++) send_set(8, 1'b1, 1'b0);
    // R4: random sizes 8..40
    for (int s = 0; s < 14; s++) send_set(8 + ($urandom % 33), 1'b1, 1'b0);
    // R7: flush through an idle gap of exactly 8, then implicit start (R2)
    idle(8);
    send_set(8, 1'b0, 1'b0);
    send_set(11, 1'b1, 1'b0);
    idle(20);
    // R2: implicit start after a long gap, then a zero-valued set
    send_set(9, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) cycle(1'b1, i == 0, '0);
    // R9: large values wrap the SUM_W-bit total
    for (int s = 0; s < 6; s++) send_set(30 + ($urandom % 11), 1'b1, 1'b1);
    send_set(8, 1'b1, 1'b0);
    idle(16);

    n_chk++;
    if (exp_sum_q.size() != 0) fail("R4", "totals never reported", exp_sum_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule